// File: doc/BRIEF.md
# Dual-Function Configuration Byte Space

This block holds the byte-addressed configuration space of a two-function device. Function 0 is a host bridge and function 1 is a bridge to a secondary bus. Each function owns 256 bytes. A simple synchronous port carries a function number, an 8-bit byte address, write data and a write strobe. Read data is combinational from the currently presented function and address.

Every write passes through a per-function policy before it reaches storage. Depending on the address, the policy ignores the write, writes only some bits, clears status bits where the written data holds a one, or stores the upper nibble with the lower nibble forced to zero. All other writable addresses take the full byte.

Three bytes of function 0, at addresses 61h, 62h and 63h, hold the shadow memory controls. They are exported as ports for a neighbouring shadow decoder. After reset every byte is zero, except the first eight bytes (00h to 07h) of each function, which come from a parameter per function.

Top module: `dual_cfg_space`

## Requirements
- R1: A read of function 0 or 1 returns the stored byte. After reset, byte i (0 to 7) of a function equals byte i of that function's header parameter (bits 8i+7:8i), and every other byte is 00h.
- R2: Reads of function numbers 2 and above return FFh. Writes to those function numbers change no stored byte of function 0 or 1.
- R3: Function 0 keeps its stored value when written at 00h–03h, 05h–06h, 08h–0Ch, 0Eh–11h, 14h–4Fh, 79h–7Dh, 85h–87h, 8Ch–A7h or ADh–FCh.
- R4: At function 0 address 04h, a write changes only bit 6 and leaves the other bits as they were.
- R5: At function 0 address 07h, bits 7, 5 and 4 are cleared where the written byte has a one. No other bit changes, and no bit is ever set by a write.
- R6: Function 0 address 12h stores bits 7:4 of the written byte with bits 3:0 forced to zero. Address 13h stores the full byte.
- R7: Function 1 keeps its stored value when written at 00h–03h, 05h–06h, 08h–17h, 1Bh, 1Eh–1Fh, 28h–3Dh or 43h–FFh.
- R8: At function 1 address 04h, only bits under mask 47h change on a write. At address 07h, bits 5 and 4 are cleared where the written byte has a one, and nothing else changes.
- R9: Function 1 addresses 20h, 22h, 24h and 26h store bits 7:4 of the written byte with bits 3:0 forced to zero.
- R10: Every writable address not named in R4–R9 stores the full written byte.
- R11: Ports shadow_c, shadow_d and shadow_ef always equal function 0 bytes 61h, 62h and 63h. They change on the clock edge that commits a write there and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fn | input | FN_W | Function number |
| cfg_addr | input | 8 | Byte address within the function |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe, committed at the rising edge |
| cfg_rdata | output | 8 | Combinational read data |
| shadow_c | output | 8 | Function 0 byte 61h |
| shadow_d | output | 8 | Function 0 byte 62h |
| shadow_ef | output | 8 | Function 0 byte 63h |

## Verification
The hardest behaviour to reach is the write-one-to-clear status. Only the header parameters can set a status bit, so a single clear destroys the state that the next test needs. The stimulus therefore uses nonzero header defaults and sweeps every address of both functions with two complementary patterns (A5h, then 5Ah). This splits the clearable bits across two separate writes, so a partial clear can be seen before the rest is cleared. A fully writable function 0 address is then written through a function number of 2 or more, to show that the stored byte is untouched.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    localparam int CFG_AW    = 8;
    localparam int CFG_DEPTH = 1 << CFG_AW;
    localparam int N_FUNC    = 2;
    localparam int N_SHADOW  = 3;

    typedef struct packed {
        logic [7:0] wr_mask;
        logic [7:0] clr_mask;
        logic [7:0] zero_mask;
    } wpol_t;

    function automatic logic host_locked(input logic [CFG_AW-1:0] a);
        return a inside {[8'h00:8'h03], [8'h05:8'h06], [8'h08:8'h0C],
                         [8'h0E:8'h11], [8'h14:8'h4F], [8'h79:8'h7D],
                         [8'h85:8'h87], [8'h8C:8'hA7], [8'hAD:8'hFC]};
    endfunction

    function automatic logic bridge_locked(input logic [CFG_AW-1:0] a);
        return a inside {[8'h00:8'h03], [8'h05:8'h06], [8'h08:8'h17],
                         8'h1B, [8'h1E:8'h1F], [8'h28:8'h3D], [8'h43:8'hFF]};
    endfunction

    function automatic wpol_t host_policy(input logic [CFG_AW-1:0] a);
        wpol_t p;
        p = '{wr_mask: 8'hFF, clr_mask: 8'h00, zero_mask: 8'h00};
        if (host_locked(a)) begin
            p.wr_mask = 8'h00;
        end else begin
            unique case (a)
                8'h04:   p.wr_mask = 8'h40;
                8'h07:   begin p.wr_mask = 8'h00; p.clr_mask = 8'hB0; end
                8'h12:   begin p.wr_mask = 8'hF0; p.zero_mask = 8'h0F; end
                default: p.wr_mask = 8'hFF;
            endcase
        end
        return p;
    endfunction

    function automatic wpol_t bridge_policy(input logic [CFG_AW-1:0] a);
        wpol_t p;
        p = '{wr_mask: 8'hFF, clr_mask: 8'h00, zero_mask: 8'h00};
        if (bridge_locked(a)) begin
            p.wr_mask = 8'h00;
        end else begin
            unique case (a)
                8'h04:   p.wr_mask = 8'h47;
                8'h07:   begin p.wr_mask = 8'h00; p.clr_mask = 8'h30; end
                8'h20, 8'h22, 8'h24, 8'h26:
                         begin p.wr_mask = 8'hF0; p.zero_mask = 8'h0F; end
                default: p.wr_mask = 8'hFF;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/dcfg_policy.sv
module dcfg_policy
    import dcfg_pkg::*;
#(
    parameter int FN_SEL = 0
) (
    input  logic [CFG_AW-1:0] addr,
    output wpol_t             pol
);

    generate
        if (FN_SEL == 0) begin : g_host
            always_comb pol = host_policy(addr);
        end else begin : g_bridge
            always_comb pol = bridge_policy(addr);
        end
    endgenerate

endmodule

// File: rtl/dcfg_store.sv
module dcfg_store
    import dcfg_pkg::*;
#(
    parameter logic [63:0]       HDR0        = 64'h0,
    parameter logic [63:0]       HDR1        = 64'h0,
    parameter logic [CFG_AW-1:0] SHADOW_BASE = 8'h61
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      fsel,
    input  logic [CFG_AW-1:0]         addr,
    input  logic [7:0]                wdata,
    input  wpol_t                     pol,
    output logic [7:0]                rdata,
    output logic [N_SHADOW-1:0][7:0]  shadow
);

    logic [7:0] mem [N_FUNC][CFG_DEPTH];
    logic [7:0] cur;
    logic [7:0] nxt;

    function automatic logic [7:0] init_byte(input int f, input int i);
        logic [63:0] h;
        h = (f == 0) ? HDR0 : HDR1;
        if (i < 8) return 8'((h >> (8 * i)) & 64'hFF);
        return 8'h00;
    endfunction

    always_comb begin
        cur = mem[fsel][addr];
        nxt = ((cur & ~pol.wr_mask) | (wdata & pol.wr_mask))
              & ~(wdata & pol.clr_mask) & ~pol.zero_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < N_FUNC; f++) begin
                for (int i = 0; i < CFG_DEPTH; i++) begin
                    mem[f][i] <= init_byte(f, i);
                end
            end
        end else if (we) begin
            mem[fsel][addr] <= nxt;
        end
    end

    assign rdata = cur;

    generate
        for (genvar k = 0; k < N_SHADOW; k++) begin : g_tap
            assign shadow[k] = mem[0][SHADOW_BASE + CFG_AW'(k)];
        end
    endgenerate

endmodule

// File: rtl/dual_cfg_space.sv
module dual_cfg_space
    import dcfg_pkg::*;
#(
    parameter int          FN_W        = 3,
    parameter logic [63:0] F0_HDR_INIT = 64'hF200_0006_3C3C_C3C3,
    parameter logic [63:0] F1_HDR_INIT = 64'h7E00_0007_9696_6969
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FN_W-1:0]   cfg_fn,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    output logic [7:0]        shadow_c,
    output logic [7:0]        shadow_d,
    output logic [7:0]        shadow_ef
);

    localparam logic [CFG_AW-1:0] SHADOW_BASE = 8'h61;

    wpol_t                    pol_fn [N_FUNC];
    wpol_t                    pol_sel;
    logic                     fn_valid;
    logic                     fsel;
    logic [7:0]               store_rd;
    logic [N_SHADOW-1:0][7:0] shadow_q;

    assign fn_valid = (cfg_fn < FN_W'(N_FUNC));
    assign fsel     = cfg_fn[0];

    generate
        for (genvar g = 0; g < N_FUNC; g++) begin : g_fn
            dcfg_policy #(.FN_SEL(g)) u_pol (
                .addr (cfg_addr),
                .pol  (pol_fn[g])
            );
        end
    endgenerate

    assign pol_sel = pol_fn[fsel];

    dcfg_store #(
        .HDR0        (F0_HDR_INIT),
        .HDR1        (F1_HDR_INIT),
        .SHADOW_BASE (SHADOW_BASE)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we && fn_valid),
        .fsel   (fsel),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .pol    (pol_sel),
        .rdata  (store_rd),
        .shadow (shadow_q)
    );

    assign cfg_rdata = fn_valid ? store_rd : 8'hFF;
    assign shadow_c  = shadow_q[0];
    assign shadow_d  = shadow_q[1];
    assign shadow_ef = shadow_q[2];

endmodule

// File: rtl/dual_cfg_space_chk.sv
module dual_cfg_space_chk #(
    parameter int FN_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FN_W-1:0] cfg_fn,
    input logic [7:0]      cfg_addr,
    input logic [7:0]      cfg_wdata,
    input logic            cfg_we,
    input logic [7:0]      cfg_rdata,
    input logic [7:0]      shadow_c,
    input logic [7:0]      shadow_d,
    input logic [7:0]      shadow_ef
);

    logic at_f0, at_f1, f0_lock, same_spot_next;
    assign at_f0   = (cfg_fn == FN_W'(0));
    assign at_f1   = (cfg_fn == FN_W'(1));
    assign f0_lock = cfg_addr inside {[8'h00:8'h03], [8'h05:8'h06], [8'h08:8'h0C],
                                      [8'h0E:8'h11], [8'h14:8'h4F], [8'h79:8'h7D],
                                      [8'h85:8'h87], [8'h8C:8'hA7], [8'hAD:8'hFC]};

    // R2
    other_fn_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fn >= FN_W'(2)) |-> (cfg_rdata == 8'hFF));

    // R3
    host_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && at_f0 && f0_lock) |=>
        (!($stable(cfg_fn) && $stable(cfg_addr)) || $stable(cfg_rdata)));

    // R5
    host_stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_f0 && cfg_addr == 8'h07) |=>
        (!(at_f0 && cfg_addr == 8'h07) || ((cfg_rdata & ~$past(cfg_rdata)) == 8'h00)));

    // R6
    host_aper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_f0 && cfg_addr == 8'h12) |-> (cfg_rdata[3:0] == 4'h0));

    // R9
    bridge_win_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_f1 && cfg_addr inside {8'h20, 8'h22, 8'h24, 8'h26}) |-> (cfg_rdata[3:0] == 4'h0));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && at_f0 && cfg_addr inside {[8'h61:8'h63]}) |=>
        $stable({shadow_c, shadow_d, shadow_ef}));

    // R11
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && at_f0 && cfg_addr == 8'h62) |=> (shadow_d == $past(cfg_wdata)));

endmodule

bind dual_cfg_space dual_cfg_space_chk #(.FN_W(FN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fn    (cfg_fn),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .shadow_c  (shadow_c),
    .shadow_d  (shadow_d),
    .shadow_ef (shadow_ef)
);

// File: tb/sim_dual_cfg_space.sv
`timescale 1ns/1ps
module sim_dual_cfg_space;

    localparam logic [63:0] H0 = 64'hF200_0006_3C3C_C3C3;
    localparam logic [63:0] H1 = 64'h7E00_0007_9696_6969;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_fn = '0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_rdata, shadow_c, shadow_d, shadow_ef;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [2][256];

    always #10 clk = ~clk;

    dual_cfg_space #(.FN_W(3), .F0_HDR_INIT(H0), .F1_HDR_INIT(H1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
        .shadow_c(shadow_c), .shadow_d(shadow_d), .shadow_ef(shadow_ef)
    );

    function automatic logic lock0(input int a);
        return (a <= 3) || (a >= 5 && a <= 6) || (a >= 8 && a <= 12) ||
               (a >= 14 && a <= 17) || (a >= 20 && a <= 79) ||
               (a >= 121 && a <= 125) || (a >= 133 && a <= 135) ||
               (a >= 140 && a <= 167) || (a >= 173 && a <= 252);
    endfunction

    function automatic logic lock1(input int a);
        return (a <= 3) || (a >= 5 && a <= 6) || (a >= 8 && a <= 23) ||
               (a == 27) || (a >= 30 && a <= 31) || (a >= 40 && a <= 61) ||
               (a >= 67);
    endfunction

    function automatic logic [7:0] next_val(input int f, input int a,
                                            input logic [7:0] old, input logic [7:0] d);
        if (f == 0) begin
            if (lock0(a)) return old;
            if (a == 4)  return (old & 8'hBF) | (d & 8'h40);
            if (a == 7)  return old & ~(d & 8'hB0);
            if (a == 18) return d & 8'hF0;
            return d;
        end
        if (lock1(a)) return old;
        if (a == 4) return (old & 8'hB8) | (d & 8'h47);
        if (a == 7) return old & ~(d & 8'h30);
        if (a == 32 || a == 34 || a == 36 || a == 38) return d & 8'hF0;
        return d;
    endfunction

    function automatic string tag_of(input int f, input int a);
        if (f == 0) begin
            if (lock0(a)) return "R3";
            if (a == 4) return "R4";
            if (a == 7) return "R5";
            if (a == 18 || a == 19) return "R6";
            return "R10";
        end
        if (lock1(a)) return "R7";
        if (a == 4 || a == 7) return "R8";
        if (a == 32 || a == 34 || a == 36 || a == 38) return "R9";
        return "R10";
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h (fn %0d addr %02h)",
                     req, act, exp, cfg_fn, cfg_addr);
        end
    endtask

    task automatic wr(input int f, input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_fn = 3'(f); cfg_addr = 8'(a); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input string req, input int f, input int a, input logic [7:0] exp);
        cfg_fn = 3'(f); cfg_addr = 8'(a);
        #1;
        check8(req, cfg_rdata, exp);
    endtask

    logic done = 1'b0;

    initial begin
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 256; a++) begin
                logic [63:0] h;
                h = (f == 0) ? H0 : H1;
                model[f][a] = (a < 8) ? 8'(h >> (8 * a)) : 8'h00;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents of both functions
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 256; a++) begin
                rd_chk("R1", f, a, model[f][a]);
            end
        end
        // R11: shadow ports after reset
        check8("R11", shadow_c, 8'h00);
        check8("R11", shadow_ef, 8'h00);

        // Sweep with two complementary patterns (R3..R10)
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 256; a++) begin
                wr(f, a, 8'hA5);
                model[f][a] = next_val(f, a, model[f][a], 8'hA5);
                rd_chk(tag_of(f, a), f, a, model[f][a]);
                wr(f, a, 8'h5A);
                model[f][a] = next_val(f, a, model[f][a], 8'h5A);
                rd_chk(tag_of(f, a), f, a, model[f][a]);
            end
        end
        // R5: status of function 0 fully cleared after both patterns
        rd_chk("R5", 0, 7, 8'h42);
        // R8: function 1 control and status
        rd_chk("R8", 1, 4, 8'h42);
        rd_chk("R8", 1, 7, 8'h4E);

        // R2: other function numbers read FFh, writes ignored
        for (int f = 2; f < 8; f++) begin
            wr(f, 8'h13, 8'h77);
            rd_chk("R2", f, 8'h13, 8'hFF);
            rd_chk("R2", 0, 8'h13, model[0][8'h13]);
            wr(f, 8'h50, 8'h33);
            rd_chk("R2", f, 8'h50, 8'hFF);
            rd_chk("R2", 0, 8'h50, model[0][8'h50]);
            rd_chk("R2", 1, 8'h40, model[1][8'h40]);
        end

        // R11: shadow export follows writes to function 0 bytes 61h..63h
        wr(0, 8'h61, 8'h3C);
        check8("R11", shadow_c, 8'h3C);
        wr(0, 8'h62, 8'hC3);
        check8("R11", shadow_d, 8'hC3);
        wr(0, 8'h63, 8'h96);
        check8("R11", shadow_ef, 8'h96);
        wr(1, 8'h61, 8'hEE);
        check8("R11", shadow_c, 8'h3C);
        wr(5, 8'h62, 8'h11);
        check8("R11", shadow_d, 8'hC3);

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 200000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule